// File: doc/BRIEF.md
# Frequency-Hopping Frame Symbol Generator

This block turns one stored payload into the symbol stream of a single frequency-hopping PHY frame. A start pulse latches the payload length, a three-bit rate code and a scrambler seed. The block then sends a fixed alternating sync run, a 16-bit frame delimiter and a 32-bit header. The header holds the length, a signalling nibble and a CRC that protects those 16 bits. After the header comes the payload. Bytes arrive on a valid/ready handshake and are whitened by a self-synchronizing scrambler before they are mapped to symbols.

The sync run, the delimiter and the header always go out as two-level FSK, one bit per symbol, using symbol index 0 or 1. The payload also goes out as two-level FSK unless the rate code selects the double rate. In that case each pair of scrambled bits becomes one Gray-coded four-level symbol. Each symbol is presented on `sym_o` together with a one-cycle strobe. Strobes are spaced a fixed number of clock cycles apart. A one-cycle done pulse marks the end of the frame.

Top module: `fhss_frame_tx`

## Requirements
- R1: After a start pulse in idle, the first 80 symbols alternate 0,1,0,1,… beginning with index 0.
- R2: The next 16 symbols are the delimiter value 0x0CBD, least significant bit first.
- R3: The next 16 symbols carry the length (12 bits, LSB first), then the signalling nibble, LSB first. Nibble bit 0 is always 0 and nibble bits 1..3 hold the rate code.
- R4: The next 16 symbols carry a CRC over the 16 header bits in transmit order. The CRC uses polynomial x^16+x^12+x^5+1 with a register preset to all ones. The result is inverted and sent CRC bit 15 first.
- R5: Every sync, delimiter and header symbol is index 0 or 1, whatever the rate code.
- R6: Payload bytes are used LSB first. Each bit d is whitened as s = d ^ r[6] ^ r[3], then s is shifted into r[0]. The 7-bit register r is loaded from the seed at start. When the rate code is not 2, each s is sent as symbol index s.
- R7: With rate code 2, each scrambled bit pair forms one symbol. The earlier bit is b0 and the later bit is b1, with v = b0 + 2*b1. The symbol index is 0, 1, 2 or 3 for v = 0, 1, 3 or 2 respectively.
- R8: Exactly `len` bytes are taken. Ready is high only during the payload, and only while no unsent bits remain and bytes are still owed.
- R9: Two strobes are never closer than CLKS_PER_SYM (default 4) cycles apart. They are exactly that far apart whenever data is available.
- R10: Done is a single-cycle pulse in the cycle after the last symbol's strobe. A length of 0 ends the frame after the header.
- R11: A start pulse while a frame is in progress is ignored.
- R12: While reset is asserted, no strobe or done is given and ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a frame when idle |
| len_i | input | 12 | Payload length in octets |
| rate_i | input | 3 | Payload rate code (2 selects four-level) |
| seed_i | input | 7 | Scrambler start value |
| byte_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte is valid |
| byte_ready_o | output | 1 | Block takes a byte this cycle if valid |
| sym_o | output | 2 | FSK symbol index |
| sym_stb_o | output | 1 | New symbol on sym_o |
| done_o | output | 1 | Frame complete pulse |

## Verification
The checker watches several properties on every cycle. It confirms that strobes never fall on adjacent cycles, that ready holds until a byte is taken and drops right after the take, and that a four-level index never appears unless the double rate was latched. It also confirms that done is a lone pulse that follows a strobe and that a start during a frame leaves the latched length untouched. The bench's frame scenarios are needed for the rest. Only they can show the exact preamble, delimiter, header and CRC symbol values, the scrambled and Gray-mapped payload, exact strobe spacing, and the byte count.

// File: rtl/fhtx_pkg.sv
package fhtx_pkg;

  localparam int LEN_W = 12;
  localparam int SIG_W = 4;
  localparam int HEC_W = 16;
  localparam int FLD_W = LEN_W + SIG_W;
  localparam int HDR_W = FLD_W + HEC_W;
  localparam int SFD_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_HDR,
    ST_PAY
  } tx_state_e;

  // Serial CRC over FLD_W bits, bit 0 fed first; preset ones, result inverted.
  function automatic logic [HEC_W-1:0] hec_calc(input logic [FLD_W-1:0] fld);
    logic [HEC_W-1:0] c;
    logic             fb;
    c = '1;
    for (int i = 0; i < FLD_W; i++) begin
      fb = c[HEC_W-1] ^ fld[i];
      c  = {c[HEC_W-2:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return ~c;
  endfunction

  // Binary dibit to Gray-ordered level index.
  function automatic logic [1:0] gray4(input logic [1:0] v);
    return {v[1], v[1] ^ v[0]};
  endfunction

endpackage

// File: rtl/fhtx_sym_timer.sv
module fhtx_sym_timer #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic fire_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (fire_i)          cnt_d = CW'(DIV - 1);
    else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/fhtx_scrambler.sv
module fhtx_scrambler #(
  parameter int W   = 7,
  parameter int TAP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv1_i,
  input  logic         adv2_i,
  input  logic         d0_i,
  input  logic         d1_i,
  output logic         s0_o,
  output logic         s1_o
);
  logic [W-1:0] r_q, r_d, r_one, r_two;

  always_comb begin
    s0_o  = d0_i ^ r_q[W-1] ^ r_q[TAP-1];
    r_one = {r_q[W-2:0], s0_o};
    s1_o  = d1_i ^ r_one[W-1] ^ r_one[TAP-1];
    r_two = {r_one[W-2:0], s1_o};
    r_d   = r_q;
    if (load_i)      r_d = seed_i;
    else if (adv2_i) r_d = r_two;
    else if (adv1_i) r_d = r_one;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else        r_q <= r_d;
  end
endmodule

// File: rtl/fhtx_hdr_gen.sv
module fhtx_hdr_gen
  import fhtx_pkg::*;
(
  input  logic [LEN_W-1:0] len_i,
  input  logic [2:0]       rate_i,
  output logic [HDR_W-1:0] hdr_o
);
  logic [FLD_W-1:0] fld;
  logic [HEC_W-1:0] hec;

  always_comb begin
    fld = {rate_i, 1'b0, len_i};
    hec = hec_calc(fld);
    hdr_o[FLD_W-1:0] = fld;
    for (int i = 0; i < HEC_W; i++) hdr_o[FLD_W+i] = hec[HEC_W-1-i];
  end
endmodule

// File: rtl/fhss_frame_tx.sv
module fhss_frame_tx
  import fhtx_pkg::*;
#(
  parameter int          CLKS_PER_SYM = 4,
  parameter int          PRE_BITS     = 80,
  parameter logic [15:0] SFD_WORD     = 16'h0CBD,
  parameter logic [2:0]  QUAD_RATE    = 3'd2,
  parameter int          SCR_W        = 7,
  parameter int          SCR_TAP      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [2:0]       rate_i,
  input  logic [SCR_W-1:0] seed_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic [1:0]       sym_o,
  output logic             sym_stb_o,
  output logic             done_o
);
  localparam int POS_W = $clog2((PRE_BITS > HDR_W) ? PRE_BITS : HDR_W);
  localparam int HIX_W = $clog2(HDR_W);
  localparam int SIX_W = $clog2(SFD_W);

  tx_state_e        state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [2:0]       rate_q, rate_d;
  logic [LEN_W-1:0] bytes_q, bytes_d;
  logic [7:0]       shr_q, shr_d;
  logic [3:0]       nbits_q, nbits_d, nbits_after;
  logic [1:0]       sym_q, sym_d;
  logic             stb_q, last_q, last_d, done_q;

  logic             tick, emit, has_bits, accept, take, quad, in_pay;
  logic             hdr_bit;
  logic             s0, s1;
  logic [HDR_W-1:0] hdr_w;

  fhtx_hdr_gen u_hdr (
    .len_i (len_q),
    .rate_i(rate_q),
    .hdr_o (hdr_w)
  );

  fhtx_sym_timer #(.DIV(CLKS_PER_SYM)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (accept),
    .fire_i(emit),
    .tick_o(tick)
  );

  fhtx_scrambler #(.W(SCR_W), .TAP(SCR_TAP)) u_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(accept),
    .seed_i(seed_i),
    .adv1_i(emit && in_pay && !quad),
    .adv2_i(emit && in_pay && quad),
    .d0_i  (shr_q[0]),
    .d1_i  (shr_q[1]),
    .s0_o  (s0),
    .s1_o  (s1)
  );

  // Per-cycle control decode
  always_comb begin
    accept       = (state_q == ST_IDLE) && start_i;
    in_pay       = (state_q == ST_PAY);
    quad         = (rate_q == QUAD_RATE);
    byte_ready_o = in_pay && (nbits_q == 4'd0) && (bytes_q != '0);
    take         = byte_ready_o && byte_valid_i;
    has_bits     = (state_q == ST_PRE) || (state_q == ST_SFD) || (state_q == ST_HDR) ||
                   (in_pay && (nbits_q != 4'd0));
    emit         = tick && has_bits;
    nbits_after  = quad ? (nbits_q - 4'd2) : (nbits_q - 4'd1);

    case (state_q)
      ST_PRE:  hdr_bit = pos_q[0];
      ST_SFD:  hdr_bit = SFD_WORD[pos_q[SIX_W-1:0]];
      default: hdr_bit = hdr_w[pos_q[HIX_W-1:0]];
    endcase

    if (in_pay) sym_d = quad ? gray4({s1, s0}) : {1'b0, s0};
    else        sym_d = {1'b0, hdr_bit};
  end

  // Next-state
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    len_d   = len_q;
    rate_d  = rate_q;
    bytes_d = bytes_q;
    shr_d   = shr_q;
    nbits_d = nbits_q;
    last_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_PRE;
          pos_d   = '0;
          len_d   = len_i;
          rate_d  = rate_i;
          bytes_d = len_i;
          nbits_d = 4'd0;
        end
      end
      ST_PRE: begin
        if (emit) begin
          if (pos_q == POS_W'(PRE_BITS - 1)) begin
            state_d = ST_SFD;
            pos_d   = '0;
          end else begin
            pos_d = pos_q + POS_W'(1);
          end
        end
      end
      ST_SFD: begin
        if (emit) begin
          if (pos_q == POS_W'(SFD_W - 1)) begin
            state_d = ST_HDR;
            pos_d   = '0;
          end else begin
            pos_d = pos_q + POS_W'(1);
          end
        end
      end
      ST_HDR: begin
        if (emit) begin
          if (pos_q == POS_W'(HDR_W - 1)) begin
            pos_d = '0;
            if (len_q == '0) begin
              state_d = ST_IDLE;
              last_d  = 1'b1;
            end else begin
              state_d = ST_PAY;
            end
          end else begin
            pos_d = pos_q + POS_W'(1);
          end
        end
      end
      ST_PAY: begin
        if (take) begin
          shr_d   = byte_i;
          nbits_d = 4'd8;
          bytes_d = bytes_q - LEN_W'(1);
        end else if (emit) begin
          shr_d   = quad ? {2'b00, shr_q[7:2]} : {1'b0, shr_q[7:1]};
          nbits_d = nbits_after;
          if ((nbits_after == 4'd0) && (bytes_q == '0)) begin
            state_d = ST_IDLE;
            last_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pos_q   <= '0;
      len_q   <= '0;
      rate_q  <= '0;
      bytes_q <= '0;
      shr_q   <= '0;
      nbits_q <= '0;
      sym_q   <= '0;
      stb_q   <= 1'b0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      len_q   <= len_d;
      rate_q  <= rate_d;
      bytes_q <= bytes_d;
      shr_q   <= shr_d;
      nbits_q <= nbits_d;
      if (emit) sym_q <= sym_d;
      stb_q   <= emit;
      last_q  <= emit && last_d;
      done_q  <= last_q;
    end
  end

  assign sym_o     = sym_q;
  assign sym_stb_o = stb_q;
  assign done_o    = done_q;
endmodule

// File: rtl/fhss_frame_tx_chk.sv
module fhss_frame_tx_chk
  import fhtx_pkg::*;
#(
  parameter logic [2:0] QUAD_RATE = 3'd2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             byte_valid_i,
  input logic             byte_ready_o,
  input logic [1:0]       sym_o,
  input logic             sym_stb_o,
  input logic             done_o,
  input tx_state_e        state_q,
  input logic [LEN_W-1:0] len_q,
  input logic [2:0]       rate_q
);

  p_stb_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb_o |=> !sym_stb_o);

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready_o && !byte_valid_i) |=> byte_ready_o);

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready_o && byte_valid_i) |=> !byte_ready_o);

  p_quad_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb_o && sym_o[1]) |-> (rate_q == QUAD_RATE));

  p_done_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(sym_stb_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && start_i) |=> $stable(len_q));

  // R12: outputs quiet while reset is held
  always @(posedge clk) begin
    if (rst_n == 1'b0) begin
      p_reset_quiet_r12: assert (!sym_stb_o && !done_o && !byte_ready_o);
    end
  end
endmodule

bind fhss_frame_tx fhss_frame_tx_chk #(.QUAD_RATE(QUAD_RATE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .byte_valid_i(byte_valid_i),
  .byte_ready_o(byte_ready_o),
  .sym_o       (sym_o),
  .sym_stb_o   (sym_stb_o),
  .done_o      (done_o),
  .state_q     (state_q),
  .len_q       (len_q),
  .rate_q      (rate_q)
);

// File: tb/fhss_frame_tx_tb.sv
module fhss_frame_tx_tb;
  localparam int DIV = 4;
  localparam int MAXS = 2048;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [11:0] len_i;
  logic [2:0]  rate_i;
  logic [6:0]  seed_i;
  logic [7:0]  byte_i;
  logic        byte_valid_i;
  logic        byte_ready_o;
  logic [1:0]  sym_o;
  logic        sym_stb_o;
  logic        done_o;

  fhss_frame_tx #(.CLKS_PER_SYM(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .rate_i(rate_i),
    .seed_i(seed_i), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .sym_o(sym_o), .sym_stb_o(sym_stb_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit clr_req = 0;
  bit finished = 0;

  int         n_sym, done_cnt, done_cyc, ready_early;
  logic [1:0] sym_log [MAXS];
  int         stb_cyc [MAXS];
  logic [1:0] exp_sym [MAXS];
  int         exp_n;
  logic [7:0] pay [64];

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (clr_req) begin
      n_sym = 0; done_cnt = 0; done_cyc = 0; ready_early = 0;
    end else begin
      if (sym_stb_o) begin
        if (n_sym < MAXS) begin
          sym_log[n_sym] = sym_o;
          stb_cyc[n_sym] = cyc;
        end
        n_sym++;
      end
      if (done_o) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (byte_ready_o && n_sym < 128) ready_early++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] f);
    logic [15:0] c = 16'hFFFF;
    logic fb;
    for (int i = 0; i < 16; i++) begin
      fb = c[15] ^ f[i];
      c  = {c[14:12], c[11] ^ fb, c[10:5], c[4] ^ fb, c[3:0], fb};
    end
    return ~c;
  endfunction

  function automatic logic [1:0] ref_map(input logic b0, input logic b1);
    case ({b1, b0})
      2'd0: return 2'd0;
      2'd1: return 2'd1;
      2'd3: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic build_exp(input int len, input logic [2:0] rate, input logic [6:0] seed);
    logic [15:0] fld, crc;
    logic [6:0]  r;
    logic        s, s0;
    bit          half;
    exp_n = 0;
    for (int i = 0; i < 80; i++) exp_sym[exp_n++] = 2'(i % 2);
    for (int i = 0; i < 16; i++) exp_sym[exp_n++] = {1'b0, 16'h0CBD >> i} & 2'b01;
    fld = {rate, 1'b0, 12'(len)};
    crc = ref_crc(fld);
    for (int i = 0; i < 16; i++) exp_sym[exp_n++] = {1'b0, fld[i]};
    for (int i = 0; i < 16; i++) exp_sym[exp_n++] = {1'b0, crc[15-i]};
    r = seed;
    half = 0;
    s0 = 0;
    for (int b = 0; b < len; b++) begin
      for (int k = 0; k < 8; k++) begin
        s = pay[b][k] ^ r[6] ^ r[3];
        r = {r[5:0], s};
        if (rate == 3'd2) begin
          if (!half) begin s0 = s; half = 1; end
          else begin exp_sym[exp_n++] = ref_map(s0, s); half = 0; end
        end else begin
          exp_sym[exp_n++] = {1'b0, s};
        end
      end
    end
  endtask

  task automatic run_frame(input int len, input logic [2:0] rate, input logic [6:0] seed,
                           input bit gaps, input bit mid_start);
    int idx, g, bad, lim, late, d;
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
    build_exp(len, rate, seed);
    @(posedge clk); clr_req = 1; @(posedge clk); clr_req = 0;
    @(negedge clk);
    len_i = 12'(len); rate_i = rate; seed_i = seed; start_i = 1;
    @(negedge clk);
    start_i = 0;
    idx = 0; g = 0;
    while ((idx < len || (mid_start && g < 40)) && g < 30000) begin
      byte_valid_i = (idx < len) && (gaps ? ($urandom % 3 != 0) : 1'b1);
      byte_i = pay[idx < len ? idx : 0];
      if (mid_start && g == 30) begin start_i = 1; len_i = 12'(len + 7); end
      else start_i = 0;
      if (byte_valid_i && byte_ready_o) idx++;
      @(negedge clk);
      g++;
    end
    byte_valid_i = 0; start_i = 0;
    g = 0;
    while (done_cnt == 0 && g < 30000) begin @(negedge clk); g++; end
    late = 0;
    repeat (6) begin @(negedge clk); if (byte_ready_o) late++; end

    lim = (n_sym < exp_n) ? n_sym : exp_n;
    chk(n_sym == exp_n, mid_start ? "R11 symbol count" : "R10 symbol count", n_sym, exp_n);
    bad = 0; for (int i = 0; i < 80 && i < lim; i++) if (sym_log[i] !== exp_sym[i]) bad++;
    chk(bad == 0, "R1 preamble", bad, 0);
    bad = 0; for (int i = 80; i < 96 && i < lim; i++) if (sym_log[i] !== exp_sym[i]) bad++;
    chk(bad == 0, "R2 delimiter", bad, 0);
    bad = 0; for (int i = 96; i < 112 && i < lim; i++) if (sym_log[i] !== exp_sym[i]) bad++;
    chk(bad == 0, "R3 header fields", bad, 0);
    bad = 0; for (int i = 112; i < 128 && i < lim; i++) if (sym_log[i] !== exp_sym[i]) bad++;
    chk(bad == 0, "R4 header crc", bad, 0);
    bad = 0; for (int i = 0; i < 128 && i < lim; i++) if (sym_log[i] > 2'd1) bad++;
    chk(bad == 0, "R5 binary header", bad, 0);
    if (len > 0) begin
      bad = 0; for (int i = 128; i < lim; i++) if (sym_log[i] !== exp_sym[i]) bad++;
      if (rate == 3'd2) chk(bad == 0, "R7 gray payload", bad, 0);
      else              chk(bad == 0, "R6 scrambled payload", bad, 0);
    end
    bad = 0;
    for (int i = 1; i < n_sym && i < MAXS; i++) begin
      d = stb_cyc[i] - stb_cyc[i-1];
      if (d < DIV) bad++;
      if ((!gaps || i < 128) && d != DIV) bad++;
    end
    chk(bad == 0, "R9 strobe spacing", bad, 0);
    chk(done_cnt == 1, "R10 done count", done_cnt, 1);
    chk(n_sym > 0 && done_cyc == stb_cyc[(n_sym - 1) % MAXS] + 1, "R10 done timing",
        done_cyc, (n_sym > 0) ? stb_cyc[(n_sym - 1) % MAXS] + 1 : 0);
    chk(idx == len, "R8 bytes taken", idx, len);
    chk(ready_early == 0 && late == 0, "R8 ready window", ready_early + late, 0);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; start_i = 0; len_i = 0; rate_i = 0; seed_i = 0; byte_i = 0; byte_valid_i = 0;
    repeat (3) @(negedge clk);
    chk(!sym_stb_o && !done_o && !byte_ready_o, "R12 reset outputs",
        {sym_stb_o, done_o, byte_ready_o}, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    run_frame(0, 3'd0, 7'h00, 0, 0);      // R10 empty payload
    run_frame(5, 3'd0, 7'h5A, 0, 0);      // R6 binary payload
    run_frame(6, 3'd2, 7'h7F, 1, 0);      // R7 four-level with gaps
    run_frame(1, 3'd2, 7'h01, 0, 0);      // R7 single byte
    run_frame(3, 3'd5, 7'h33, 0, 1);      // R11 start during frame
    for (int n = 0; n < 6; n++)
      run_frame(1 + ($urandom % 24), 3'($urandom), 7'($urandom), 1'($urandom), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule